// File: doc/BRIEF.md
# Path-Compressed Trie Longest-Prefix-Match Engine

This block finds the longest stored prefix that covers a 32-bit destination address by walking a binary trie in which one-child nodes have been removed. Every node carries the index of the next address bit worth testing, so the walk jumps straight to the branching decisions. Because bits are skipped on the way down, a node that carries a prefix compares that whole prefix against the leading bits of the address. A match becomes the best result so far. A mismatch ends the walk.

Software or a loader fills a 64-entry node store through a simple write port, with the root at index 0. A lookup is started with a one-cycle request while the engine is ready. The engine reads one node per fetch/evaluate pair. It returns a one-cycle done pulse together with the next hop of the last matching prefix, or a miss flag with a zero next hop when no prefix on the path matched.

Top module: `trie_lpm_engine`

## Requirements
- R1: A walk begins at node index 0. At each node the address bit at the node's position is tested, with position 1 being address bit 31 and position 32 being bit 0. A 0 follows the left pointer and a 1 follows the right pointer.
- R2: At a node flagged as a prefix, the top `plen` bits of the address are compared with the top `plen` bits of the stored prefix, which is left-aligned in 32 bits. On equality, the node's next hop becomes the best match. A length of 0 matches every address.
- R3: A prefix comparison that fails ends the walk, and the result is the best match recorded before that node.
- R4: The walk also ends when the selected child pointer is the null value 63 (all ones), or when the node's bit position is outside 1..32. The node's own prefix is still evaluated first.
- R5: When no prefix matched during the walk, the result has `res_miss`=1 and `res_hop`=0. Otherwise it has `res_miss`=0 and the matching next hop.
- R6: Each visited node costs two cycles. `res_done` is high for exactly one cycle, 2n edges after the edge that accepts the request, for n visited nodes. `res_hop` and `res_miss` then hold until the next result.
- R7: A walk visits at most 32 nodes and then stops with the best match found so far, even if the trie contains a cycle.
- R8: `lk_ready` is high only while idle. A request raised while busy is ignored and does not change the running walk's result.
- R9: A write with `wr_en` high stores the node at `wr_idx`, and that node is used by any lookup started afterwards.
- R10: After reset, `lk_ready`=1, `res_done`=0, `res_miss`=0 and `res_hop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | 6 | Node index to write |
| wr_pos | input | 6 | Bit position tested at this node (1..32) |
| wr_left | input | 6 | Child for address bit 0 (63 = none) |
| wr_right | input | 6 | Child for address bit 1 (63 = none) |
| wr_is_pfx | input | 1 | Node carries a prefix |
| wr_prefix | input | 32 | Prefix bits, left-aligned |
| wr_plen | input | 6 | Prefix length, 0..32 |
| wr_hop | input | 8 | Next hop for this prefix |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to look up |
| lk_ready | output | 1 | Engine idle and accepting a request |
| res_done | output | 1 | One-cycle result strobe |
| res_miss | output | 1 | No prefix matched |
| res_hop | output | 8 | Next hop of the longest match |

## Verification
Addresses are driven against a nine-prefix trie and chosen to separate the outcomes. Some reach a deeper prefix that matches. Some reach a deeper prefix whose skipped bits differ, and must fall back to a shorter match. Others exit through a null pointer or through an out-of-range bit position. Each case also checks the latency, which confirms the number of nodes visited. Directed cases cover these points:
- Removing a prefix flag produces a miss.
- Rewriting a node changes the next hop returned.
- A self-looping node with a zero-length prefix stops the walk at the visit limit.
- A request raised mid-walk leaves the running result unchanged.

// File: rtl/trie_pkg.sv
package trie_pkg;
    parameter int ADDR_W     = 32;
    parameter int PTR_W      = 6;
    parameter int HOP_W      = 8;
    parameter int MAX_VISITS = 32;

    localparam int DEPTH = 1 << PTR_W;
    localparam int POS_W = $clog2(ADDR_W + 1);
    localparam int VIS_W = $clog2(MAX_VISITS + 1);
    localparam logic [PTR_W-1:0] NULL_PTR = {PTR_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [PTR_W-1:0]  left;
        logic [PTR_W-1:0]  right;
        logic              is_pfx;
        logic [ADDR_W-1:0] prefix;
        logic [POS_W-1:0]  plen;
        logic [HOP_W-1:0]  hop;
    } node_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_EVAL,
        S_DONE
    } state_t;
endpackage

// File: rtl/trie_node_ram.sv
module trie_node_ram
    import trie_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  node_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output node_t            rdata
);
    node_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/trie_prefix_match.sv
module trie_prefix_match
    import trie_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prefix,
    input  logic [POS_W-1:0]  plen,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;
    logic [POS_W-1:0]  drop;

    always_comb begin
        drop = POS_W'(ADDR_W) - plen;
        mask = {ADDR_W{1'b1}} << drop;
        hit  = (plen <= POS_W'(ADDR_W)) && (((addr ^ prefix) & mask) == '0);
    end
endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine
    import trie_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [PTR_W-1:0]  wr_left,
    input  logic [PTR_W-1:0]  wr_right,
    input  logic              wr_is_pfx,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [POS_W-1:0]  wr_plen,
    input  logic [HOP_W-1:0]  wr_hop,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              res_done,
    output logic              res_miss,
    output logic [HOP_W-1:0]  res_hop
);
    typedef struct packed {
        state_t            state;
        logic [ADDR_W-1:0] addr;
        logic [PTR_W-1:0]  ptr;
        logic [HOP_W-1:0]  best;
        logic              have;
        logic [VIS_W-1:0]  visits;
        logic [HOP_W-1:0]  out_hop;
        logic              out_miss;
    } eng_t;

    eng_t  eng_d, eng_q;
    node_t node_w, node_r;
    logic  pfx_hit;

    assign node_w = '{pos: wr_pos, left: wr_left, right: wr_right, is_pfx: wr_is_pfx,
                      prefix: wr_prefix, plen: wr_plen, hop: wr_hop};

    trie_node_ram u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_idx),
        .wdata (node_w),
        .raddr (eng_q.ptr),
        .rdata (node_r)
    );

    trie_prefix_match u_cmp (
        .addr   (eng_q.addr),
        .prefix (node_r.prefix),
        .plen   (node_r.plen),
        .hit    (pfx_hit)
    );

    logic [ADDR_W-1:0] shifted;
    logic              pos_ok, bit_v, stop, go, new_have;
    logic [PTR_W-1:0]  child;
    logic [HOP_W-1:0]  new_best;
    logic [VIS_W-1:0]  vis_next;

    always_comb begin
        eng_d    = eng_q;
        pos_ok   = (node_r.pos != '0) && (node_r.pos <= POS_W'(ADDR_W));
        shifted  = eng_q.addr << (node_r.pos - POS_W'(1));
        bit_v    = shifted[ADDR_W-1];
        child    = bit_v ? node_r.right : node_r.left;
        vis_next = eng_q.visits + VIS_W'(1);
        stop     = node_r.is_pfx && !pfx_hit;
        new_have = eng_q.have | (node_r.is_pfx & pfx_hit);
        new_best = (node_r.is_pfx && pfx_hit) ? node_r.hop : eng_q.best;
        go       = !stop && pos_ok && (child != NULL_PTR) && (vis_next < VIS_W'(MAX_VISITS));

        unique case (eng_q.state)
            S_IDLE: begin
                if (lk_valid) begin
                    eng_d.addr   = lk_addr;
                    eng_d.ptr    = '0;
                    eng_d.best   = '0;
                    eng_d.have   = 1'b0;
                    eng_d.visits = '0;
                    eng_d.state  = S_FETCH;
                end
            end
            S_FETCH: eng_d.state = S_EVAL;
            S_EVAL: begin
                eng_d.visits = vis_next;
                eng_d.have   = new_have;
                eng_d.best   = new_best;
                if (go) begin
                    eng_d.ptr   = child;
                    eng_d.state = S_FETCH;
                end else begin
                    eng_d.out_hop  = new_have ? new_best : '0;
                    eng_d.out_miss = !new_have;
                    eng_d.state    = S_DONE;
                end
            end
            S_DONE: eng_d.state = S_IDLE;
            default: eng_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: S_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign lk_ready = (eng_q.state == S_IDLE);
    assign res_done = (eng_q.state == S_DONE);
    assign res_miss = eng_q.out_miss;
    assign res_hop  = eng_q.out_hop;
endmodule

// File: rtl/trie_lpm_checker.sv
module trie_lpm_checker
    import trie_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             res_done,
    input logic             res_miss,
    input logic [HOP_W-1:0] res_hop
);
    localparam int BUSY_MAX = 2 * MAX_VISITS + 1;
    localparam int CNT_W    = $clog2(BUSY_MAX + 2);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (lk_ready) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + CNT_W'(1);
        end
    end

    // R6: the result strobe lasts a single cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    // R5: a miss always reports a zero next hop
    p_miss_zero_hop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_miss) |-> (res_hop == '0));

    // R8: an accepted request makes the engine busy
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready);

    // R8: done is never signalled while idle
    p_done_not_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> !lk_ready);

    // R6: an idle engine without a request keeps its result
    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ready && !lk_valid) |=> ($stable(res_hop) && $stable(res_miss)));

    // R7: the walk is bounded by the visit limit
    p_visit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(BUSY_MAX));
endmodule

bind trie_lpm_engine trie_lpm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .res_done (res_done),
    .res_miss (res_miss),
    .res_hop  (res_hop)
);

// File: tb/sim_trie_lpm_engine.sv
module sim_trie_lpm_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0, wr_pos = '0, wr_left = '0, wr_right = '0, wr_plen = '0;
    logic        wr_is_pfx = 1'b0;
    logic [31:0] wr_prefix = '0;
    logic [7:0]  wr_hop = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, res_done, res_miss;
    logic [7:0]  res_hop;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trie_lpm_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pos(wr_pos),
        .wr_left(wr_left), .wr_right(wr_right), .wr_is_pfx(wr_is_pfx),
        .wr_prefix(wr_prefix), .wr_plen(wr_plen), .wr_hop(wr_hop),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
        .res_done(res_done), .res_miss(res_miss), .res_hop(res_hop)
    );

    // address, expected hop, expected miss, expected nodes visited
    localparam logic [31:0] V_ADDR [NVEC] = '{32'h5800_0000, 32'hB000_0000, 32'h6000_0000,
        32'h4000_0000, 32'h4400_0000, 32'h2000_0000, 32'hD000_0000, 32'hF000_0000,
        32'hC000_0000, 32'h8000_0000, 32'hE800_0000, 32'h1000_0000};
    localparam logic [7:0] V_HOP [NVEC] = '{8'd1, 8'd4, 8'd3, 8'd2, 8'd2, 8'd1,
        8'd7, 8'd9, 8'd6, 8'd5, 8'd8, 8'd1};
    localparam int V_NODES [NVEC] = '{3, 3, 3, 3, 3, 3, 5, 5, 5, 3, 5, 3};

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_node(input int idx, input int pos, input int l, input int r,
                            input logic pfx, input logic [31:0] pv, input int len, input int hop);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_pos = 6'(pos); wr_left = 6'(l); wr_right = 6'(r);
        wr_is_pfx = pfx; wr_prefix = pv; wr_plen = 6'(len); wr_hop = 8'(hop);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, output logic [7:0] hop,
                          output logic miss, output int cyc);
        @(negedge clk);
        lk_addr = a; lk_valid = 1'b1; cyc = 0;
        @(posedge clk); cyc++;
        @(negedge clk); lk_valid = 1'b0;
        while (!res_done) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        hop = res_hop; miss = res_miss;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] hop;
        logic       miss;
        int         cyc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        check("R10 ready", lk_ready == 1'b1, lk_ready, 1);
        check("R10 done", res_done == 1'b0, res_done, 0);
        check("R10 hop/miss", res_hop == 8'd0 && res_miss == 1'b0, {res_miss, res_hop}, 0);
        rst_n = 1'b1;

        // R9: load the trie (null child = 63)
        put_node(0,  1, 1, 2,   0, 32'h0, 0, 0);
        put_node(1,  3, 3, 4,   1, 32'h0000_0000, 1, 1);
        put_node(3,  0, 63, 63, 1, 32'h4000_0000, 5, 2);
        put_node(4,  0, 63, 63, 1, 32'h6000_0000, 3, 3);
        put_node(2,  2, 5, 6,   1, 32'h8000_0000, 1, 4);
        put_node(5,  0, 63, 63, 1, 32'h8000_0000, 3, 5);
        put_node(6,  3, 7, 8,   0, 32'h0, 0, 0);
        put_node(7,  4, 9, 10,  0, 32'h0, 0, 0);
        put_node(8,  4, 11, 12, 0, 32'h0, 0, 0);
        put_node(9,  5, 63, 63, 1, 32'hC000_0000, 4, 6);
        put_node(10, 5, 63, 63, 1, 32'hD000_0000, 4, 7);
        put_node(11, 5, 63, 63, 1, 32'hE000_0000, 4, 8);
        put_node(12, 5, 63, 63, 1, 32'hF000_0000, 4, 9);

        // R1 R2 R3 R4 R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            lookup(V_ADDR[i], hop, miss, cyc);
            check("R1/R2/R3 hop", hop == V_HOP[i], hop, V_HOP[i]);
            check("R5 miss clear", miss == 1'b0, miss, 0);
            check("R4/R6 latency", cyc == 2 * V_NODES[i] + 1, cyc, 2 * V_NODES[i] + 1);
        end

        // R6: done is one cycle, result held
        @(negedge clk);
        check("R6 done pulse", res_done == 1'b0, res_done, 0);
        repeat (4) @(negedge clk);
        check("R6 hold", res_hop == 8'd1, res_hop, 1);

        // R8: request while busy ignored
        @(negedge clk);
        lk_addr = 32'h5800_0000; lk_valid = 1'b1;
        @(negedge clk); lk_valid = 1'b0;
        @(negedge clk);
        check("R8 busy", lk_ready == 1'b0, lk_ready, 0);
        lk_addr = 32'hF000_0000; lk_valid = 1'b1;
        @(negedge clk); lk_valid = 1'b0;
        while (!res_done) @(negedge clk);
        check("R8 ignored", res_hop == 8'd1, res_hop, 1);
        @(negedge clk);
        check("R8 idle after", lk_ready == 1'b1 && res_done == 1'b0, lk_ready, 1);

        // R9: rewrite a leaf hop
        put_node(12, 5, 63, 63, 1, 32'hF000_0000, 4, 8'h2A);
        lookup(32'hF000_0000, hop, miss, cyc);
        check("R9 rewrite", hop == 8'h2A, hop, 8'h2A);

        // R5: remove the only shallow prefix, walk ends with no match
        put_node(1, 3, 3, 4, 0, 32'h0, 1, 1);
        lookup(32'h1000_0000, hop, miss, cyc);
        check("R5 miss", miss == 1'b1, miss, 1);
        check("R5 hop zero", hop == 8'd0, hop, 0);
        check("R3 stop", cyc == 7, cyc, 7);

        // R7: self loop with zero-length prefix stops at the visit cap
        put_node(20, 1, 20, 20, 1, 32'h0, 0, 8'h33);
        put_node(0, 1, 20, 20, 0, 32'h0, 0, 0);
        lookup(32'h1234_5678, hop, miss, cyc);
        check("R7 hop", hop == 8'h33 && miss == 1'b0, hop, 8'h33);
        check("R7 visits", cyc == 65, cyc, 65);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule